// File: doc/BRIEF.md
# Byte Lane Mask, Extract and Insert Unit

This unit rearranges and clears bytes inside a 64-bit word. It is the helper an integer pipeline uses when it loads or stores a value that is not aligned to a quadword. The value is then split across two quadwords. The low forms of each operation handle the part of the field in the lower quadword, and the high forms handle the part that spills into the next one. The unit also offers a byte zap, which clears any chosen set of byte lanes.

Each operation takes three inputs: a data operand A, a position operand B and a 7-bit function code. The low three bits of B select a byte offset. For zap, the low eight bits of B are a lane select. The result is computed combinationally and captured in an output register when the input is marked valid. A flag reports any code that names no defined operation.

Top module: `bytelane_unit`

## Requirements
- R1: The byte offset is `opb[2:0]` and the bit shift is 8 times that offset. Bits 63:3 of `opb` have no effect on mask, extract and insert results.
- R2: Mask-low (function 0x02, 0x12, 0x22, 0x32 for a field of 1, 2, 4, 8 bytes) clears in A an all-ones field of that width shifted left by the bit shift. Field bits pushed beyond bit 63 are lost.
- R3: Mask-high (0x52, 0x62, 0x72 for 2, 4, 8 bytes) returns A unchanged at offset 0. Otherwise it clears in A the width field shifted right by 64 minus the bit shift.
- R4: Extract-low (0x06, 0x16, 0x26, 0x36 for 1, 2, 4, 8 bytes) shifts A right logically by the bit shift and keeps only the low field width; the bits above it are zero.
- R5: Extract-high (0x5a, 0x6a, 0x7a for 2, 4, 8 bytes) shifts A left by (64 minus the bit shift) modulo 64, so it does not shift at offset 0, and keeps the low field width.
- R6: Insert-low (0x0b, 0x1b, 0x2b, 0x3b for 1, 2, 4, 8 bytes) shifts the low field width of A left by the bit shift, truncated to 64 bits.
- R7: Insert-high (0x57, 0x67, 0x77 for 2, 4, 8 bytes) returns zero at offset 0. Otherwise it shifts the low field width of A right by 64 minus the bit shift.
- R8: Zap (0x30) clears byte lane i of A, bits 8i+7:8i, when `opb[i]` is 1. Zap-not (0x31) clears lane i when `opb[i]` is 0.
- R9: Any other function code, including the 1-byte high forms 0x42, 0x4a and 0x47, sets `illegal` with a zero `result`. Legal codes clear `illegal`.
- R10: `out_valid` is `in_valid` delayed by one clock, and `result` and `illegal` belong to the operation accepted on that earlier edge.
- R11: While `in_valid` is low, `result` and `illegal` hold their values whatever the other inputs do.
- R12: Synchronous reset clears `out_valid`, `result` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| func | input | 7 | Function code |
| opa | input | 64 | Data operand |
| opb | input | 64 | Byte offset in bits 2:0, lane select in bits 7:0 |
| out_valid | output | 1 | Result register holds a new operation |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered undefined-code flag |

## Verification
Every legal code is swept over all eight offsets. Three data patterns are used for this sweep:
- A value with a distinct number in every byte shows whether lanes end up in the right position.
- An all-ones value exposes fields that are cut too wide or too narrow.
- A random value catches mixed cases.

Offset 0 is the step that separates the high forms' special cases (pass-through, no shift, zero) from a naive shift by 64. Random upper bits in B show that only the offset bits steer the shifts. Walking and random lane selects on zap and zap-not, plus undefined codes interleaved with idle cycles, separate the lane logic, the illegal flag and the hold behaviour.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

    localparam int DATA_W  = 64;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int OFF_W   = $clog2(LANES);
    localparam int SH_W    = OFF_W + $clog2(LANE_W);
    localparam int FUNC_W  = 7;
    localparam int WSEL_W  = 2;

    typedef enum logic [2:0] {
        OPK_MASK   = 3'd0,
        OPK_EXTR   = 3'd1,
        OPK_INSR   = 3'd2,
        OPK_ZAP    = 3'd3,
        OPK_NONE   = 3'd4
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic                high;
        logic                keep_sel;
        logic [WSEL_W-1:0]   wsel;
        logic                illegal;
    } op_ctl_t;

    // All-ones field of (1 << wsel) byte lanes, right aligned.
    function automatic logic [DATA_W-1:0] width_field(input logic [WSEL_W-1:0] wsel);
        logic [DATA_W-1:0] f;
        f = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < (1 << wsel)) f[j*LANE_W +: LANE_W] = '1;
        end
        return f;
    endfunction

endpackage

// File: rtl/bytelane_decode.sv
module bytelane_decode
    import bytelane_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output op_ctl_t           ctl
);

    always_comb begin
        ctl          = '0;
        ctl.kind     = OPK_NONE;
        ctl.wsel     = func[5:4];
        ctl.illegal  = 1'b0;
        case (func)
            7'h02, 7'h12, 7'h22, 7'h32: ctl.kind = OPK_MASK;
            7'h52, 7'h62, 7'h72: begin
                ctl.kind = OPK_MASK;
                ctl.high = 1'b1;
            end
            7'h06, 7'h16, 7'h26, 7'h36: ctl.kind = OPK_EXTR;
            7'h5a, 7'h6a, 7'h7a: begin
                ctl.kind = OPK_EXTR;
                ctl.high = 1'b1;
            end
            7'h0b, 7'h1b, 7'h2b, 7'h3b: ctl.kind = OPK_INSR;
            7'h57, 7'h67, 7'h77: begin
                ctl.kind = OPK_INSR;
                ctl.high = 1'b1;
            end
            7'h30: ctl.kind = OPK_ZAP;
            7'h31: begin
                ctl.kind     = OPK_ZAP;
                ctl.keep_sel = 1'b1;
            end
            default: ctl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/bytelane_core.sv
module bytelane_core
    import bytelane_pkg::*;
(
    input  op_ctl_t            ctl,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);

    logic [OFF_W-1:0]  off;
    logic [SH_W-1:0]   lsh;       // 8 * offset
    logic [SH_W-1:0]   wrap_sh;   // (64 - 8 * offset) mod 64
    logic [SH_W:0]     hsh;       // 64 - 8 * offset, used only when offset != 0
    logic              zero_off;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] a_fld;
    logic [DATA_W-1:0] lane_clr;

    assign off      = b[OFF_W-1:0];
    assign lsh      = {off, {(SH_W-OFF_W){1'b0}}};
    assign wrap_sh  = SH_W'(0) - lsh;
    assign hsh      = (SH_W+1)'(DATA_W) - {1'b0, lsh};
    assign zero_off = (off == '0);
    assign field    = width_field(ctl.wsel);
    assign a_fld    = a & field;

    // Lane expansion for zap: each select bit covers one byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_clr[g*LANE_W +: LANE_W] = {LANE_W{b[g] ^ ctl.keep_sel}};
    end

    always_comb begin
        y = '0;
        case (ctl.kind)
            OPK_MASK: begin
                if (!ctl.high)     y = a & ~(field << lsh);
                else if (zero_off) y = a;
                else               y = a & ~(field >> hsh);
            end
            OPK_EXTR: begin
                if (!ctl.high) y = (a >> lsh) & field;
                else           y = (a << wrap_sh) & field;
            end
            OPK_INSR: begin
                if (!ctl.high)     y = a_fld << lsh;
                else if (zero_off) y = '0;
                else               y = a_fld >> hsh;
            end
            OPK_ZAP:  y = a & ~lane_clr;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/bytelane_unit.sv
module bytelane_unit
    import bytelane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [6:0]        func,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic              illegal
);

    op_ctl_t           ctl;
    logic [DATA_W-1:0] core_y;

    bytelane_decode u_decode (
        .func (func),
        .ctl  (ctl)
    );

    bytelane_core u_core (
        .ctl (ctl),
        .a   (opa),
        .b   (opb),
        .y   (core_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= ctl.illegal ? '0 : core_y;
                illegal <= ctl.illegal;
            end
        end
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal))); // R11
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0)); // R9
    AST_MSKH_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 7'h72 && opb[2:0] == 3'd0) |=> (result == $past(opa))); // R3
    AST_INSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 7'h77 && opb[2:0] == 3'd0) |=> (result == '0)); // R7
    AST_ZAP_ALL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func == 7'h30 && opb[7:0] == 8'hff) |=> (result == '0 && !illegal)); // R8

endmodule

// File: tb/bytelane_unit_tb.sv
`timescale 1ns/1ps
module bytelane_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    logic [63:0] q_exp[$];
    logic        q_ill[$];
    string       q_tag[$];

    logic [63:0] last_res;
    logic        last_ill;
    bit          have_last = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    bytelane_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .illegal(illegal)
    );

    // Byte-lane reference model built from the requirements.
    function automatic logic [64:0] model(input logic [6:0] f, input logic [63:0] a,
                                          input logic [63:0] b);
        int cat; int w; int off; bit hi;
        logic [63:0] r;
        off = int'(b[2:0]);
        w   = 1 << f[5:4];
        hi  = 0;
        case (f)
            7'h02, 7'h12, 7'h22, 7'h32: cat = 0;
            7'h52, 7'h62, 7'h72: begin cat = 0; hi = 1; end
            7'h06, 7'h16, 7'h26, 7'h36: cat = 1;
            7'h5a, 7'h6a, 7'h7a: begin cat = 1; hi = 1; end
            7'h0b, 7'h1b, 7'h2b, 7'h3b: cat = 2;
            7'h57, 7'h67, 7'h77: begin cat = 2; hi = 1; end
            7'h30: cat = 3;
            7'h31: cat = 4;
            default: cat = 5;
        endcase
        r = '0;
        for (int j = 0; j < 8; j++) begin
            logic [7:0] v;
            int s;
            v = 8'h00;
            case (cat)
                0: begin
                    if (!hi) v = (j >= off && j < off + w) ? 8'h00 : a[8*j +: 8];
                    else if (off == 0) v = a[8*j +: 8];
                    else v = (j < off + w - 8) ? 8'h00 : a[8*j +: 8];
                end
                1: begin
                    if (!hi) s = j + off;
                    else s = (off == 0) ? j : j - (8 - off);
                    if (j < w && s >= 0 && s < 8) v = a[8*s +: 8];
                end
                2: begin
                    if (!hi) s = j - off;
                    else s = (off == 0) ? 99 : j + 8 - off;
                    if (s >= 0 && s < w) v = a[8*s +: 8];
                end
                3: v = b[j] ? 8'h00 : a[8*j +: 8];
                4: v = b[j] ? a[8*j +: 8] : 8'h00;
                default: v = 8'h00;
            endcase
            r[8*j +: 8] = v;
        end
        return {(cat == 5), r};
    endfunction

    function automatic string tag_of(input logic [6:0] f);
        case (f)
            7'h02, 7'h12, 7'h22, 7'h32: return "R2";
            7'h52, 7'h62, 7'h72:        return "R3";
            7'h06, 7'h16, 7'h26, 7'h36: return "R4";
            7'h5a, 7'h6a, 7'h7a:        return "R5";
            7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R6";
            7'h57, 7'h67, 7'h77:        return "R7";
            7'h30, 7'h31:               return "R8";
            default:                    return "R9";
        endcase
    endfunction

    task automatic send(input logic [6:0] f, input logic [63:0] a,
                        input logic [63:0] b, input string tag);
        logic [64:0] m;
        @(posedge clk); #1;
        in_valid = 1'b1; func = f; opa = a; opb = b;
        m = model(f, a, b);
        q_exp.push_back(m[63:0]);
        q_ill.push_back(m[64]);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            func = 7'($urandom);
            opa  = {$urandom, $urandom};
            opb  = {$urandom, $urandom};
        end
    endtask

    // Monitor: R10 pairing of results to accepted operations, R11 hold.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                checks++;
                if (q_exp.size() == 0) begin
                    errors++;
                    $display("FAIL R10: out_valid with no pending operation, actual result %h expected none", result);
                end else begin
                    logic [63:0] e; logic ei; string t;
                    e = q_exp.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
                    if (result !== e || illegal !== ei) begin
                        errors++;
                        $display("FAIL %s: actual result %h illegal %b expected result %h illegal %b",
                                 t, result, illegal, e, ei);
                    end
                    last_res = e; last_ill = ei; have_last = 1;
                end
            end else if (have_last) begin
                checks++;
                if (result !== last_res || illegal !== last_ill) begin
                    errors++;
                    $display("FAIL R11: actual result %h illegal %b expected held %h %b",
                             result, illegal, last_res, last_ill);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10: watchdog expired, actual pending %0d expected 0", q_exp.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [6:0] codes [23];
        logic [63:0] pats [3];
        codes = '{7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
                  7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
                  7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77,
                  7'h30, 7'h31};
        pats = '{64'h8877665544332211, 64'hffffffffffffffff, 64'h0};

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R12 reset state
        if (out_valid !== 1'b0 || result !== 64'h0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R12: actual out_valid %b result %h illegal %b expected 0 0 0",
                     out_valid, result, illegal);
        end
        @(posedge clk); #1;
        rst = 1'b0;

        // Sweep of all legal codes over every offset.
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 23; c++) begin
                for (int o = 0; o < 8; o++) begin
                    logic [63:0] a;
                    a = (p == 2) ? {$urandom, $urandom} : pats[p];
                    send(codes[c], a, 64'(o), tag_of(codes[c]));
                end
                if (c % 5 == 0) idle(2);
            end
        end

        // R1: upper bits of B carry garbage, only offset bits steer shifts.
        for (int n = 0; n < 120; n++) begin
            logic [6:0] f;
            f = codes[$urandom % 21];
            send(f, {$urandom, $urandom}, {$urandom, $urandom}, "R1");
        end

        // R8: walking and random lane selects.
        for (int i = 0; i < 8; i++) begin
            send(7'h30, pats[0], 64'(1 << i), "R8");
            send(7'h31, pats[0], 64'(1 << i), "R8");
        end
        send(7'h30, pats[1], 64'hff, "R8");
        send(7'h31, pats[1], 64'h00, "R8");
        for (int n = 0; n < 30; n++)
            send(7'($urandom % 2 + 32'h30), {$urandom, $urandom}, {$urandom, $urandom}, "R8");

        // R9: undefined codes, including 1-byte high forms, then a legal one.
        send(7'h42, pats[1], 64'd3, "R9");
        idle(3);
        send(7'h4a, pats[1], 64'd3, "R9");
        send(7'h47, pats[1], 64'd3, "R9");
        send(7'h00, pats[0], 64'd1, "R9");
        send(7'h7f, pats[0], 64'd1, "R9");
        send(7'h32, pats[1], 64'd0, "R9");
        for (int n = 0; n < 40; n++) begin
            logic [6:0] f;
            f = 7'($urandom);
            send(f, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(f));
            if (n % 7 == 0) idle(1);
        end

        // R10/R11: gap after a final operation, inputs toggling.
        send(7'h16, pats[0], 64'd3, "R10");
        idle(6);

        wait (q_exp.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule